// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Codes

This unit carries out the data operations of a small accumulator processor on 8-bit values and produces a new condition-code byte. Each operation is presented for one cycle with `in_vld` high. The unit takes an operation code, a primary operand, a second operand and the current condition codes. One clock later it presents the result, the updated condition codes and a flag that tells the register file whether to write the accumulator back.

The operation set covers the usual single-operand operations: negate, complement, increment, decrement, clear, logical shift left and logical shift right. It also covers the two-operand operations add, subtract, compare, AND, OR and exclusive OR. Three irregular variants are included as well. The first negates or complements depending on the incoming carry. The second decrements and reports in carry whether the operand was non-zero. The third clears the operand but keeps carry. Instruction fetch, memory traffic and 16-bit arithmetic are handled elsewhere.

Condition-code bit positions: C bit 0, V bit 1, Z bit 2, N bit 3, I bit 4, H bit 5, F bit 6, E bit 7.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first operation is accepted, `out_vld`, `out_wr`, `out_res` and `out_cc` are all zero.
- R2: An operation accepted with `in_vld` high appears on the outputs on the next clock edge, with `out_vld` high for that cycle. When `in_vld` is low, `out_vld` drops and `out_res`, `out_cc` and `out_wr` hold their values. Operations may be issued on consecutive cycles.
- R3: `in_op` encodes the operations as follows: 0 negate, 1 complement, 2 increment, 3 decrement, 4 clear, 5 shift left, 6 shift right, 7 add, 8 subtract, 9 compare, 10 AND, 11 OR, 12 exclusive OR, 13 carry-selected negate/complement, 14 decrement with non-zero carry, 15 clear keeping carry. For every operation, N equals bit 7 of `out_res`, and Z is set exactly when `out_res` is zero.
- R4: E, F and I pass from `in_cc` to `out_cc` unchanged. H is also passed through, except for add.
- R5: Add returns (a+b) mod 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is the two's-complement overflow.
- R6: Subtract and compare compute a−b. C is set when b>a as unsigned values, and V is the signed overflow. Compare drives `out_wr` low. Every other operation drives `out_wr` high.
- R7: Increment sets V only for operand 0x7F. Decrement sets V only for operand 0x80. Both keep C.
- R8: Negate returns 0−a, sets V only for 0x80 and sets C when the operand is non-zero. Complement returns the bitwise inverse, clears V and sets C.
- R9: Shift left moves the old bit 7 into C and sets V to old bit 7 XOR old bit 6. Shift right moves the old bit 0 into C, clears N and keeps V.
- R10: Clear returns zero and sets Z while clearing N, V and C. Clear-keeping-carry returns zero and sets Z while clearing N and V, and leaves C as it was.
- R11: AND, OR and exclusive OR clear V and keep C.
- R12: Operation 13 behaves as negate when the incoming C is 0 and as complement when it is 1 (0x05 becomes 0xFB with C=0, and 0xAA becomes 0x55 with C=1).
- R13: Operation 14 returns a−1 with V set only for 0x80, and sets C exactly when the operand was non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operation strobe |
| in_op | input | 4 | Operation code (see R3) |
| in_a | input | 8 | Primary operand |
| in_b | input | 8 | Second operand for two-operand operations |
| in_cc | input | 8 | Current condition codes |
| out_vld | output | 1 | Result valid, one cycle after the strobe |
| out_res | output | 8 | Operation result |
| out_cc | output | 8 | Updated condition codes |
| out_wr | output | 1 | Write the result to the accumulator |

## Verification
Two things can meet in one cycle. The first is the capture of a new operation in the same cycle that the previous result is being presented. The bench issues operations back to back and checks each result in the cycle it is due, before the next one overwrites it. The second is the incoming carry. It is both an operand selector (operation 13) and a flag that other operations must carry through. Every operation code is therefore swept with the incoming carry both set and clear, and each outcome is compared with an integer model that treats the two roles separately.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OPW = 4;
  localparam int CCW = 8;

  typedef enum logic [OPW-1:0] {
    OP_NEG  = 4'd0,
    OP_COM  = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_CLR  = 4'd4,
    OP_LSL  = 4'd5,
    OP_LSR  = 4'd6,
    OP_ADD  = 4'd7,
    OP_SUB  = 4'd8,
    OP_CMP  = 4'd9,
    OP_AND  = 4'd10,
    OP_OR   = 4'd11,
    OP_EOR  = 4'd12,
    OP_XNC  = 4'd13,
    OP_XDEC = 4'd14,
    OP_XCLR = 4'd15
  } alu_op_e;

  // condition-code byte, MSB first
  typedef struct packed {
    logic e;
    logic f;
    logic h;
    logic i;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  // operations served by the shared adder
  function automatic logic uses_adder(alu_op_e op);
    case (op)
      OP_NEG, OP_INC, OP_DEC, OP_ADD,
      OP_SUB, OP_CMP, OP_XDEC: return 1'b1;
      default:                 return 1'b0;
    endcase
  endfunction

  // the carry-selected variant resolves to one of two plain operations
  function automatic alu_op_e resolve_op(alu_op_e op, logic carry);
    if (op == OP_XNC) return carry ? OP_COM : OP_NEG;
    return op;
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e        op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  ccr_t           cc_in,
  output logic [DW-1:0]  res,
  output ccr_t           cc_out
);

  localparam int HB = DW / 2;

  function automatic logic [DW:0] wide_sum(logic [DW-1:0] x, logic [DW-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
  endfunction

  function automatic logic low_carry(logic [DW-1:0] x, logic [DW-1:0] y, logic ci);
    logic [HB:0] t;
    t = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, ci};
    return t[HB];
  endfunction

  function automatic logic signed_ovf(logic xm, logic ym, logic sm);
    return (xm == ym) && (sm != xm);
  endfunction

  logic [DW-1:0] add_x;
  logic [DW-1:0] add_y;
  logic          add_ci;
  logic [DW:0]   add_sum;
  logic          carry_out;
  logic          half_carry;
  logic          sgn_ovf;

  // operand steering: every operation here is x + y + ci
  always_comb begin
    add_x  = a;
    add_y  = b;
    add_ci = 1'b0;
    case (op)
      OP_ADD:          begin add_x = a;        add_y = b;        add_ci = 1'b0; end
      OP_SUB, OP_CMP:  begin add_x = a;        add_y = ~b;       add_ci = 1'b1; end
      OP_NEG:          begin add_x = '0;       add_y = ~a;       add_ci = 1'b1; end
      OP_INC:          begin add_x = a;        add_y = '0;       add_ci = 1'b1; end
      OP_DEC, OP_XDEC: begin add_x = a;        add_y = '1;       add_ci = 1'b0; end
      default:         begin add_x = a;        add_y = b;        add_ci = 1'b0; end
    endcase
  end

  assign add_sum    = wide_sum(add_x, add_y, add_ci);
  assign res        = add_sum[DW-1:0];
  assign carry_out  = add_sum[DW];
  assign half_carry = low_carry(add_x, add_y, add_ci);
  assign sgn_ovf    = signed_ovf(add_x[DW-1], add_y[DW-1], add_sum[DW-1]);

  always_comb begin
    cc_out   = cc_in;
    cc_out.n = res[DW-1];
    cc_out.z = ~|res;
    cc_out.v = sgn_ovf;
    case (op)
      OP_ADD: begin
        cc_out.c = carry_out;
        cc_out.h = half_carry;
      end
      OP_SUB, OP_CMP, OP_NEG: cc_out.c = ~carry_out;  // borrow
      OP_XDEC:                cc_out.c = carry_out;   // a + 0xFF carries iff a != 0
      default:                cc_out.c = cc_in.c;
    endcase
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e        op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  ccr_t           cc_in,
  output logic [DW-1:0]  res,
  output ccr_t           cc_out
);

  logic shl_out;
  logic shr_out;
  logic shl_sign_flip;

  assign shl_out       = a[DW-1];
  assign shr_out       = a[0];
  assign shl_sign_flip = a[DW-1] ^ a[DW-2];

  always_comb begin
    res    = '0;
    cc_out = cc_in;
    case (op)
      OP_COM: begin
        res      = ~a;
        cc_out.v = 1'b0;
        cc_out.c = 1'b1;
      end
      OP_CLR: begin
        res      = '0;
        cc_out.v = 1'b0;
        cc_out.c = 1'b0;
      end
      OP_XCLR: begin
        res      = '0;
        cc_out.v = 1'b0;
      end
      OP_LSL: begin
        res      = {a[DW-2:0], 1'b0};
        cc_out.c = shl_out;
        cc_out.v = shl_sign_flip;
      end
      OP_LSR: begin
        res      = {1'b0, a[DW-1:1]};
        cc_out.c = shr_out;
      end
      OP_AND: begin
        res      = a & b;
        cc_out.v = 1'b0;
      end
      OP_OR: begin
        res      = a | b;
        cc_out.v = 1'b0;
      end
      OP_EOR: begin
        res      = a ^ b;
        cc_out.v = 1'b0;
      end
      default: begin
        res = a;
      end
    endcase
    cc_out.n = res[DW-1];
    cc_out.z = ~|res;
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [3:0]    in_op,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [7:0]    in_cc,
  output logic          out_vld,
  output logic [DW-1:0] out_res,
  output logic [7:0]    out_cc,
  output logic          out_wr
);

  localparam int MSB = DW - 1;

  alu_op_e       op_in;
  alu_op_e       eff_op;
  ccr_t          cc_now;
  logic          take_adder;
  logic [DW-1:0] ar_res;
  logic [DW-1:0] lg_res;
  ccr_t          ar_cc;
  ccr_t          lg_cc;
  logic [DW-1:0] nxt_res;
  ccr_t          nxt_cc;
  logic          nxt_wr;

  assign op_in      = alu_op_e'(in_op);
  assign cc_now     = ccr_t'(in_cc);
  assign eff_op     = resolve_op(op_in, cc_now.c);
  assign take_adder = uses_adder(eff_op);

  alu8_arith #(.DW(DW)) u_arith (
    .op     (eff_op),
    .a      (in_a),
    .b      (in_b),
    .cc_in  (cc_now),
    .res    (ar_res),
    .cc_out (ar_cc)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op     (eff_op),
    .a      (in_a),
    .b      (in_b),
    .cc_in  (cc_now),
    .res    (lg_res),
    .cc_out (lg_cc)
  );

  assign nxt_res = take_adder ? ar_res : lg_res;
  assign nxt_cc  = take_adder ? ar_cc  : lg_cc;
  assign nxt_wr  = (op_in != OP_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_res <= '0;
      out_cc  <= '0;
      out_wr  <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_res <= nxt_res;
        out_cc  <= nxt_cc;
        out_wr  <= nxt_wr;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld && $stable(out_res) && $stable(out_cc) && $stable(out_wr)); // R2

  AST_NZ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_cc[3] == out_res[MSB]) && (out_cc[2] == (out_res == '0))); // R3

  AST_EFI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_cc[7] == $past(in_cc[7]) && out_cc[6] == $past(in_cc[6]) && out_cc[4] == $past(in_cc[4])); // R4

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && (in_op == OP_CMP) |=> !out_wr); // R6

  AST_INC_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && (in_op == OP_INC) && (in_a == {1'b0, {MSB{1'b1}}}) |=> out_cc[1]); // R7

  AST_COM_SETS_C: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && ((in_op == OP_COM) || ((in_op == OP_XNC) && in_cc[0])) |=> out_cc[0]); // R12

  AST_XCLR_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && (in_op == OP_XCLR) |=> (out_res == '0) && (out_cc[0] == $past(in_cc[0]))); // R10

endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic [3:0] in_op = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic [7:0] in_cc = '0;
  logic       out_vld;
  logic [7:0] out_res;
  logic [7:0] out_cc;
  logic       out_wr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_cc(in_cc),
    .out_vld(out_vld), .out_res(out_res), .out_cc(out_cc), .out_wr(out_wr)
  );

  // integer reference: returns {wr, result, cc}
  function automatic logic [16:0] model(int op, int a, int b, logic [7:0] cc);
    int r, sa, sb, s;
    bit c, v, h, wr;
    c = cc[0]; v = cc[1]; h = cc[5]; wr = 1; r = 0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    if (op == 13) op = cc[0] ? 1 : 0;
    case (op)
      0:  begin r = (256 - a) % 256; v = (a == 128); c = (a != 0); end
      1:  begin r = 255 - a; v = 0; c = 1; end
      2:  begin r = (a + 1) % 256; v = (a == 127); end
      3:  begin r = (a + 255) % 256; v = (a == 128); end
      4:  begin r = 0; v = 0; c = 0; end
      5:  begin r = (a * 2) % 256; c = (a >= 128); v = (((a >> 7) & 1) != ((a >> 6) & 1)); end
      6:  begin r = a / 2; c = (a % 2) == 1; end
      7:  begin r = (a + b) % 256; c = (a + b) > 255; h = ((a % 16) + (b % 16)) > 15;
                s = sa + sb; v = (s > 127) || (s < -128); end
      8, 9: begin r = (a - b + 256) % 256; c = (a < b); s = sa - sb;
                v = (s > 127) || (s < -128); wr = (op != 9); end
      10: begin r = a & b; v = 0; end
      11: begin r = a | b; v = 0; end
      12: begin r = a ^ b; v = 0; end
      14: begin r = (a + 255) % 256; v = (a == 128); c = (a != 0); end
      default: begin r = 0; v = 0; end
    endcase
    return {wr, r[7:0], cc[7], cc[6], h, cc[4], (r > 127), (r == 0), v, c};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input int op, input logic [7:0] a, b, cc, input string tag);
    logic [16:0] e;
    e = model(op, a, b, cc);
    chk(out_vld === 1'b1, tag, "out_vld", {7'd0, out_vld}, 8'd1);
    chk(out_res === e[15:8], tag, "out_res", out_res, e[15:8]);
    chk(out_cc === e[7:0], tag, "out_cc", out_cc, e[7:0]);
    chk(out_wr === e[16], tag, "out_wr", {7'd0, out_wr}, {7'd0, e[16]});
  endtask

  task automatic run_op(input int op, input logic [7:0] a, b, cc, input string tag);
    @(negedge clk);
    in_op = op[3:0]; in_a = a; in_b = b; in_cc = cc; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    compare(op, a, b, cc, tag);
  endtask

  task automatic t_reset();
    chk(out_vld === 1'b0, "R1", "out_vld", {7'd0, out_vld}, 8'd0);
    chk(out_res === 8'h00, "R1", "out_res", out_res, 8'h00);
    chk(out_cc === 8'h00, "R1", "out_cc", out_cc, 8'h00);
    chk(out_wr === 1'b0, "R1", "out_wr", {7'd0, out_wr}, 8'd0);
  endtask

  task automatic t_add();
    run_op(7, 8'h0F, 8'h01, 8'h00, "R5 half carry");
    run_op(7, 8'h7F, 8'h01, 8'hD0, "R5 overflow R4 pass");
    run_op(7, 8'hFF, 8'h01, 8'h00, "R5 carry zero");
    run_op(7, 8'h80, 8'h80, 8'h20, "R5 neg overflow");
  endtask

  task automatic t_sub_cmp();
    run_op(8, 8'h30, 8'h10, 8'h00, "R6 sub");
    run_op(8, 8'h00, 8'h01, 8'h20, "R6 borrow R4 H kept");
    run_op(8, 8'h80, 8'h01, 8'h00, "R6 overflow");
    run_op(9, 8'h42, 8'h42, 8'h00, "R6 cmp no write");
  endtask

  task automatic t_inc_dec();
    run_op(2, 8'h7F, 8'h00, 8'h01, "R7 inc 7F");
    run_op(2, 8'hFF, 8'h00, 8'h00, "R7 inc FF");
    run_op(3, 8'h80, 8'h00, 8'h01, "R7 dec 80");
    run_op(3, 8'h00, 8'h00, 8'h00, "R7 dec 00");
  endtask

  task automatic t_neg_com();
    run_op(0, 8'h05, 8'h00, 8'h00, "R8 neg");
    run_op(0, 8'h00, 8'h00, 8'h01, "R8 neg zero");
    run_op(0, 8'h80, 8'h00, 8'h00, "R8 neg 80");
    run_op(1, 8'hAA, 8'h00, 8'h02, "R8 com");
  endtask

  task automatic t_shift();
    run_op(5, 8'h81, 8'h00, 8'h00, "R9 lsl carry");
    run_op(5, 8'h40, 8'h00, 8'h01, "R9 lsl overflow");
    run_op(6, 8'h03, 8'h00, 8'h00, "R9 lsr carry");
    run_op(6, 8'h80, 8'h00, 8'h0A, "R9 lsr keep V");
  endtask

  task automatic t_clear();
    run_op(4, 8'h42, 8'h00, 8'hFF, "R10 clr");
    run_op(15, 8'hFF, 8'h00, 8'h0B, "R10 xclr keep C set");
    run_op(15, 8'h11, 8'h00, 8'h0A, "R10 xclr keep C clear");
  endtask

  task automatic t_bitwise();
    run_op(10, 8'hFF, 8'h0F, 8'h03, "R11 and");
    run_op(11, 8'hF0, 8'h0F, 8'h02, "R11 or");
    run_op(12, 8'hFF, 8'h0F, 8'h01, "R11 eor");
    run_op(10, 8'hF0, 8'h0F, 8'h00, "R11 and zero");
  endtask

  task automatic t_xnc();
    run_op(13, 8'h05, 8'h00, 8'h00, "R12 C0 neg");
    run_op(13, 8'hAA, 8'h00, 8'h01, "R12 C1 com");
    run_op(13, 8'h00, 8'h00, 8'h00, "R12 C0 zero");
    run_op(13, 8'h00, 8'h00, 8'h01, "R12 C1 zero");
  endtask

  task automatic t_xdec();
    run_op(14, 8'h03, 8'h00, 8'h00, "R13 nonzero");
    run_op(14, 8'h00, 8'h00, 8'h01, "R13 zero");
    run_op(14, 8'h80, 8'h00, 8'h00, "R13 overflow");
    run_op(14, 8'h01, 8'h00, 8'h00, "R13 to zero");
  endtask

  task automatic t_hold();
    logic [7:0] r0, c0;
    logic       w0;
    run_op(7, 8'h12, 8'h34, 8'h00, "R2 setup");
    r0 = out_res; c0 = out_cc; w0 = out_wr;
    in_op = 4'd4; in_a = 8'hFF; in_b = 8'hFF; in_cc = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    chk(out_vld === 1'b0, "R2 hold", "out_vld", {7'd0, out_vld}, 8'd0);
    chk(out_res === r0, "R2 hold", "out_res", out_res, r0);
    chk(out_cc === c0, "R2 hold", "out_cc", out_cc, c0);
    chk(out_wr === w0, "R2 hold", "out_wr", {7'd0, out_wr}, {7'd0, w0});
  endtask

  task automatic t_stream();
    @(negedge clk);
    in_op = 4'd9; in_a = 8'h10; in_b = 8'h20; in_cc = 8'h00; in_vld = 1'b1;
    @(negedge clk);
    compare(9, 8'h10, 8'h20, 8'h00, "R2 stream first");
    in_op = 4'd13; in_a = 8'h5A; in_b = 8'h00; in_cc = 8'h01;
    @(negedge clk);
    compare(13, 8'h5A, 8'h00, 8'h01, "R2 stream second");
    in_op = 4'd2; in_a = 8'hFE; in_cc = 8'h00;
    @(negedge clk);
    in_vld = 1'b0;
    compare(2, 8'hFE, 8'h00, 8'h00, "R2 stream third");
  endtask

  task automatic t_sweep();
    logic [7:0] pat [5] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h5A};
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 5; k++) begin
        run_op(op, pat[k], pat[k] ^ 8'h3C, (k % 2) ? 8'hF1 : 8'h0E, "R3 sweep");
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub_cmp();
    t_inc_dec();
    t_neg_com();
    t_shift();
    t_clear();
    t_bitwise();
    t_xnc();
    t_xdec();
    t_hold();
    t_stream();
    t_sweep();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule